// File: doc/BRIEF.md
# Block Forward Cosine Transform with Quantizer

This block takes one 8x8 tile of signed pixels, computes its two-dimensional forward discrete cosine transform in fixed point, divides each coefficient by 64 with an arithmetic shift, and hands the 64 results back one at a time. Pixels are pushed in row-major order. A start pulse launches the transform once a full tile has been loaded. The coefficients are then popped in row-major order, with the horizontal frequency varying fastest.

The arithmetic is separable. A first pass forms, for every pixel row x and column frequency v, the dot product of that row with the cosine column v. The sum is brought back to integer scale. A second pass combines those partial sums down each column with the row-frequency cosines. Each finished sum is then multiplied by a single normalization constant, which merges the 1/4 factor, the two DC weights and the quantizing shift into one multiply and one shift. All of this work runs on one shared multiplier, so a transform always takes the same number of cycles.

The cosine constants are Q15 integers, with 1.0 stored as 32768. The DC weight 1/sqrt(2) is stored as 23170.

Top module: `dct_fdct_8x8`

## Requirements
- R1: While reset is high and after it is released, busy and done are 0 and coef_out is 0 until a transform completes.
- R2: The n-th push accepted since reset or since the last completed transform writes pix_in into cell n mod 64, where cell x*8+y holds pixel D[x][y]. A later push overwrites an earlier one in the same cell. A push while busy is ignored.
- R3: A start is accepted only when busy is 0 and at least 64 pushes have been accepted since reset or since the last completed transform. Any other start is ignored and busy stays 0.
- R4: After an accepted start, busy is 1 for exactly 1088 cycles. Done rises in the cycle busy falls and stays 1 until the next accepted start. Busy and done are never 1 together.
- R5: The first pass forms T[x][v] = floor(sum over y of D[x][y]*K[y][v] / 2^15). The cosine table entry K[i][k] is cos(pi*(2i+1)*k/16)*32768 truncated toward zero, so K[i][0] = 32768 and K[0][1..7] = 32138, 30273, 27245, 23170, 18204, 12539, 6392.
- R6: Coefficient (u,v) is floor(S*N(u,v) / 2^38), keeping its low 16 bits, where S = sum over x of T[x][v]*K[x][u]. N(u,v) is 16383 when u and v are both 0, 23170 when exactly one of them is 0, and 32768 otherwise. A tile whose pixels are all 100 gives a DC coefficient of 12.
- R7: While busy is 0, coef_out shows the coefficient at the read position u*8+v. Each pop with busy at 0 advances the read position by one, and after position 63 it returns to 0. Without a pop, coef_out holds its value while idle.
- R8: When a transform completes, the read position, the write position and the push count all return to 0. A start right after done is therefore ignored until 64 new pushes have been made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| push | input | 1 | Store pix_in at the write position |
| pix_in | input | PIX_W (8) | Signed pixel value |
| start | input | 1 | Request a transform of the loaded tile |
| pop | input | 1 | Advance the read position |
| busy | output | 1 | Transform in progress |
| done | output | 1 | Coefficients of the last transform are ready |
| coef_out | output | COEF_W (16) | Signed coefficient at the read position |

## Verification
The bench builds the block with its default parameters: 8-bit pixels, 16-bit coefficients and a shift of 6. These settings make the extreme tiles reachable: uniform -128 and 127, a full-swing checkerboard and a single impulse. Together with random tiles they drive the largest accumulator magnitudes and all three normalization cases of the 64 output positions. The 6-bit read and write positions are small enough that the bench also covers push wrap-around (a 74-push load) and readout wrap-around (128 pops of one result).

// File: rtl/dct_pkg.sv
package dct_pkg;

    localparam int BLK_N     = 8;
    localparam int BLK_CELLS = BLK_N * BLK_N;
    localparam int IDX_W     = $clog2(BLK_N);
    localparam int CELL_W    = $clog2(BLK_CELLS);
    localparam int COS_FRAC  = 15;
    localparam int COS_W     = COS_FRAC + 2;   // room for +1.0 = 32768 and sign

    // Shared-multiplier schedule: 8 MACs per pass-1 sum,
    // 8 MACs plus one normalizing multiply per output coefficient.
    localparam int ROW_CYC   = BLK_CELLS * BLK_N;
    localparam int COL_CYC   = BLK_CELLS * (BLK_N + 1);
    localparam int XFORM_CYC = ROW_CYC + COL_CYC;

    // Normalization constants (1/4 * C(u) * C(v)) before the fixed /4 shift.
    localparam logic signed [COS_W-1:0] NRM_DC   = COS_W'(16383);
    localparam logic signed [COS_W-1:0] NRM_EDGE = COS_W'(23170);
    localparam logic signed [COS_W-1:0] NRM_AC   = COS_W'(32768);

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_ROWS,
        PH_COLS,
        PH_NORM
    } phase_e;

    typedef struct packed {
        logic [IDX_W-1:0] outer;
        logic [IDX_W-1:0] mid;
        logic [IDX_W-1:0] inner;
    } step_t;

    // Q15 cosine of pi*(2i+1)*k/16, built from the first-octant values by symmetry.
    function automatic logic signed [COS_W-1:0] cos_q15(input int i, input int k);
        int  m;
        int  mag;
        logic neg;
        m = ((2 * i + 1) * k) % (4 * BLK_N);
        if (m > 2 * BLK_N) m = 4 * BLK_N - m;
        neg = (m > BLK_N);
        if (neg) m = 2 * BLK_N - m;
        case (m)
            0:       mag = 32768;
            1:       mag = 32138;
            2:       mag = 30273;
            3:       mag = 27245;
            4:       mag = 23170;
            5:       mag = 18204;
            6:       mag = 12539;
            7:       mag = 6392;
            default: mag = 0;
        endcase
        return COS_W'(neg ? -mag : mag);
    endfunction

endpackage

// File: rtl/dct_coef_rom.sv
module dct_coef_rom
    import dct_pkg::*;
(
    input  logic [IDX_W-1:0]        cos_row,
    input  logic [IDX_W-1:0]        cos_col,
    input  logic [IDX_W-1:0]        nrm_u,
    input  logic [IDX_W-1:0]        nrm_v,
    output logic signed [COS_W-1:0] cos_val,
    output logic signed [COS_W-1:0] nrm_val
);

    logic signed [COS_W-1:0] tbl [BLK_CELLS];

    for (genvar g = 0; g < BLK_CELLS; g++) begin : g_tbl
        assign tbl[g] = cos_q15(g / BLK_N, g % BLK_N);
    end

    assign cos_val = tbl[{cos_row, cos_col}];

    always_comb begin
        unique case ({nrm_u == '0, nrm_v == '0})
            2'b11:        nrm_val = NRM_DC;
            2'b10, 2'b01: nrm_val = NRM_EDGE;
            default:      nrm_val = NRM_AC;
        endcase
    end

endmodule

// File: rtl/dct_mac.sv
module dct_mac #(
    parameter int A_W = 31,
    parameter int B_W = 17
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      en,
    input  logic                      first,
    input  logic signed [A_W-1:0]     op_a,
    input  logic signed [B_W-1:0]     op_b,
    output logic signed [A_W+B_W-1:0] prod,
    output logic signed [A_W+B_W-1:0] sum_nx,
    output logic signed [A_W-1:0]     acc_lo
);

    localparam int P_W = A_W + B_W;

    logic signed [P_W-1:0] acc_q;

    assign prod   = op_a * op_b;
    assign sum_nx = (first ? P_W'(0) : acc_q) + prod;
    assign acc_lo = acc_q[A_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
        end else if (en) begin
            acc_q <= sum_nx;
        end
    end

endmodule

// File: rtl/dct_seq.sv
module dct_seq
    import dct_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   go,
    output phase_e phase,
    output step_t  step,
    output logic   busy,
    output logic   mac_en,
    output logic   mac_first,
    output logic   tmp_we,
    output logic   out_we,
    output logic   finish
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(BLK_N - 1);

    phase_e ph_q;
    step_t  st_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q <= PH_IDLE;
            st_q <= '0;
        end else begin
            unique case (ph_q)
                PH_IDLE: begin
                    if (go) begin
                        ph_q <= PH_ROWS;
                        st_q <= '0;
                    end
                end
                PH_ROWS: begin
                    st_q.inner <= st_q.inner + 1'b1;
                    if (st_q.inner == LAST) begin
                        st_q.mid <= st_q.mid + 1'b1;
                        if (st_q.mid == LAST) begin
                            st_q.outer <= st_q.outer + 1'b1;
                            if (st_q.outer == LAST) ph_q <= PH_COLS;
                        end
                    end
                end
                PH_COLS: begin
                    st_q.inner <= st_q.inner + 1'b1;
                    if (st_q.inner == LAST) ph_q <= PH_NORM;
                end
                PH_NORM: begin
                    st_q.mid <= st_q.mid + 1'b1;
                    if (st_q.mid == LAST) st_q.outer <= st_q.outer + 1'b1;
                    if (st_q.mid == LAST && st_q.outer == LAST) ph_q <= PH_IDLE;
                    else                                        ph_q <= PH_COLS;
                end
                default: ph_q <= PH_IDLE;
            endcase
        end
    end

    assign phase     = ph_q;
    assign step      = st_q;
    assign busy      = (ph_q != PH_IDLE);
    assign mac_en    = (ph_q == PH_ROWS) || (ph_q == PH_COLS);
    assign mac_first = (st_q.inner == '0);
    assign tmp_we    = (ph_q == PH_ROWS) && (st_q.inner == LAST);
    assign out_we    = (ph_q == PH_NORM);
    assign finish    = (ph_q == PH_NORM) && (st_q.mid == LAST) && (st_q.outer == LAST);

endmodule

// File: rtl/dct_fdct_8x8.sv
module dct_fdct_8x8
    import dct_pkg::*;
#(
    parameter int PIX_W  = 8,
    parameter int COEF_W = 16,
    parameter int QSHIFT = 6
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     push,
    input  logic signed [PIX_W-1:0]  pix_in,
    input  logic                     start,
    input  logic                     pop,
    output logic                     busy,
    output logic                     done,
    output logic signed [COEF_W-1:0] coef_out
);

    // Pass-1 result: sum of 8 pixels times at most 1.0, back at integer scale.
    localparam int TMP_W   = PIX_W + IDX_W + 1;
    // Pass-2 sum in Q15: 8 partials times at most 1.0.
    localparam int MUL_A_W = TMP_W + IDX_W + COS_FRAC + 1;
    localparam int P_W     = MUL_A_W + COS_W;
    // Two Q15 scalings, the 1/4 factor and the quantizer in one shift.
    localparam int NORM_SH = 2 * COS_FRAC + 2 + QSHIFT;
    localparam logic [CELL_W:0] FULL = (CELL_W + 1)'(BLK_CELLS);

    logic signed [PIX_W-1:0]  ibuf [BLK_CELLS];
    logic signed [TMP_W-1:0]  tbuf [BLK_CELLS];
    logic signed [COEF_W-1:0] obuf [BLK_CELLS];

    logic [CELL_W-1:0] wr_idx;
    logic [CELL_W-1:0] rd_idx;
    logic [CELL_W:0]   fill;
    logic              done_q;

    phase_e phase;
    step_t  step;
    logic   seq_busy, mac_en, mac_first, tmp_we, out_we, finish;
    logic   go;

    logic [IDX_W-1:0]        rom_row, rom_col;
    logic signed [COS_W-1:0] cos_val, nrm_val;

    logic signed [MUL_A_W-1:0] op_a;
    logic signed [COS_W-1:0]   op_b;
    logic signed [P_W-1:0]     prod, sum_nx;
    logic signed [MUL_A_W-1:0] acc_lo;

    logic signed [TMP_W-1:0]   tmp_val;
    logic signed [COEF_W-1:0]  coef_val;

    assign go = start && !seq_busy && (fill == FULL);

    dct_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .go        (go),
        .phase     (phase),
        .step      (step),
        .busy      (seq_busy),
        .mac_en    (mac_en),
        .mac_first (mac_first),
        .tmp_we    (tmp_we),
        .out_we    (out_we),
        .finish    (finish)
    );

    dct_coef_rom u_rom (
        .cos_row (rom_row),
        .cos_col (rom_col),
        .nrm_u   (step.outer),
        .nrm_v   (step.mid),
        .cos_val (cos_val),
        .nrm_val (nrm_val)
    );

    // Operand routing for the single multiplier.
    always_comb begin
        rom_row = step.inner;
        rom_col = step.mid;
        op_a    = '0;
        op_b    = '0;
        unique case (phase)
            PH_ROWS: begin
                // D[x=outer][y=inner] * K[y][v=mid]
                op_a = MUL_A_W'(ibuf[{step.outer, step.inner}]);
                op_b = cos_val;
            end
            PH_COLS: begin
                // T[x=inner][v=mid] * K[x][u=outer]
                rom_col = step.outer;
                op_a    = MUL_A_W'(tbuf[{step.inner, step.mid}]);
                op_b    = cos_val;
            end
            PH_NORM: begin
                op_a = acc_lo;
                op_b = nrm_val;
            end
            default: begin
                op_a = '0;
                op_b = '0;
            end
        endcase
    end

    dct_mac #(
        .A_W (MUL_A_W),
        .B_W (COS_W)
    ) u_mac (
        .clk    (clk),
        .rst    (rst),
        .en     (mac_en),
        .first  (mac_first),
        .op_a   (op_a),
        .op_b   (op_b),
        .prod   (prod),
        .sum_nx (sum_nx),
        .acc_lo (acc_lo)
    );

    assign tmp_val  = TMP_W'(sum_nx >>> COS_FRAC);
    assign coef_val = COEF_W'(prod >>> NORM_SH);

    // Input tile storage.
    always_ff @(posedge clk) begin
        if (push && !seq_busy) begin
            ibuf[wr_idx] <= pix_in;
        end
    end

    // Pass-1 partial sums.
    always_ff @(posedge clk) begin
        if (tmp_we) begin
            tbuf[{step.outer, step.mid}] <= tmp_val;
        end
    end

    // Output coefficient storage.
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < BLK_CELLS; i++) obuf[i] <= '0;
        end else if (out_we) begin
            obuf[{step.outer, step.mid}] <= coef_val;
        end
    end

    // Positions, load count and completion flag.
    always_ff @(posedge clk) begin
        if (rst) begin
            wr_idx <= '0;
            rd_idx <= '0;
            fill   <= '0;
            done_q <= 1'b0;
        end else begin
            if (finish) begin
                wr_idx <= '0;
                rd_idx <= '0;
                fill   <= '0;
            end else begin
                if (push && !seq_busy) begin
                    wr_idx <= wr_idx + 1'b1;
                    if (fill != FULL) fill <= fill + 1'b1;
                end
                if (pop && !seq_busy) begin
                    rd_idx <= rd_idx + 1'b1;
                end
            end
            if (finish)  done_q <= 1'b1;
            else if (go) done_q <= 1'b0;
        end
    end

    assign busy     = seq_busy;
    assign done     = done_q;
    assign coef_out = obuf[rd_idx];

endmodule

// File: rtl/dct_fdct_chk.sv
module dct_fdct_chk #(
    parameter int COEF_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic              pop,
    input logic              busy,
    input logic              done,
    input logic [COEF_W-1:0] coef_out
);

    logic [15:0] run_len;

    always_ff @(posedge clk) begin
        if (rst)       run_len <= '0;
        else if (busy) run_len <= run_len + 16'd1;
        else           run_len <= '0;
    end

    AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(busy && done)); // R4

    AST_BUSY_NEEDS_START: assert property (@(posedge clk) disable iff (rst)
        !busy && !start |=> !busy); // R3

    AST_RUN_LENGTH: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> run_len == 16'(dct_pkg::XFORM_CYC)); // R4

    AST_DONE_HOLD: assert property (@(posedge clk) disable iff (rst)
        done && !start |=> done); // R4

    AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> $past(busy)); // R4

    AST_COEF_STABLE: assert property (@(posedge clk) disable iff (rst)
        !busy && !pop |=> $stable(coef_out)); // R7

endmodule

bind dct_fdct_8x8 dct_fdct_chk #(.COEF_W(COEF_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .pop      (pop),
    .busy     (busy),
    .done     (done),
    .coef_out (coef_out)
);

// File: tb/dct_fdct_8x8_tb.sv
module dct_fdct_8x8_tb;

    logic              clk    = 1'b0;
    logic              rst    = 1'b1;
    logic              push   = 1'b0;
    logic              start  = 1'b0;
    logic              pop    = 1'b0;
    logic signed [7:0] pix_in = '0;
    logic              busy, done;
    logic signed [15:0] coef_out;

    int    n_chk = 0;
    int    n_bad = 0;
    int    exp_q[$];
    string tag_q[$];
    int    cq[8][8];
    int    src[80];
    int    blk[64];

    always #4 clk = ~clk;   // 125 MHz

    dct_fdct_8x8 u_dut (
        .clk      (clk),
        .rst      (rst),
        .push     (push),
        .pix_in   (pix_in),
        .start    (start),
        .pop      (pop),
        .busy     (busy),
        .done     (done),
        .coef_out (coef_out)
    );

    task automatic check(input string tag, input int act, input int expv);
        n_chk++;
        if (act != expv) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    // Monitor: compare every popped coefficient against the scoreboard.
    always @(negedge clk) begin
        if (!rst && pop) begin
            if (exp_q.size() == 0) begin
                check("R7 unexpected pop", int'(coef_out), 99999);
            end else begin
                check(tag_q.pop_front(), int'(coef_out), exp_q.pop_front());
            end
        end
    end

    // Reference model from R5 and R6, pushed into the scoreboard.
    task automatic expect_block(input string tag);
        longint t[8][8];
        longint s, a, k, q;
        logic signed [15:0] w;
        for (int x = 0; x < 8; x++) begin
            for (int v = 0; v < 8; v++) begin
                s = 0;
                for (int y = 0; y < 8; y++) s += longint'(blk[x*8+y]) * cq[y][v];
                t[x][v] = s >>> 15;
            end
        end
        for (int u = 0; u < 8; u++) begin
            for (int v = 0; v < 8; v++) begin
                a = 0;
                for (int x = 0; x < 8; x++) a += t[x][v] * cq[x][u];
                k = (u == 0 && v == 0) ? 16383 : ((u == 0 || v == 0) ? 23170 : 32768);
                q = (a * k) >>> 38;
                w = q[15:0];
                exp_q.push_back(int'(w));
                tag_q.push_back(tag);
            end
        end
    endtask

    task automatic push_range(input int lo, input int hi);
        for (int i = lo; i < hi; i++) begin
            push   = 1'b1;
            pix_in = 8'(src[i]);
            blk[i % 64] = src[i];
            tick();
        end
        push = 1'b0;
    endtask

    task automatic run_xform(input string tag, input bit junk);
        int cnt;
        cnt   = 0;
        start = 1'b1;
        tick();
        start = 1'b0;
        for (int w = 0; w < 5000; w++) begin
            @(negedge clk);
            if (done) break;
            if (busy) cnt++;
            push   = junk;
            pix_in = 8'sd77;
        end
        push = 1'b0;
        check({tag, " R4 busy cycles"}, cnt, 1088);
        check({tag, " R4 done high"}, int'(done), 1);
        check({tag, " R4 busy low at done"}, int'(busy), 0);
        @(posedge clk);
        #1;
    endtask

    task automatic drain(input int n);
        for (int i = 0; i < n; i++) begin
            pop = 1'b1;
            tick();
        end
        pop = 1'b0;
    endtask

    task automatic try_ignored_start(input string tag);
        start = 1'b1;
        tick();
        start = 1'b0;
        @(negedge clk);
        check({tag, " busy stays low"}, int'(busy), 0);
        @(posedge clk);
        #1;
    endtask

    initial begin
        #(8 * 150000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog R4 actual=timeout expected=completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 8; i++)
            for (int k = 0; k < 8; k++)
                cq[i][k] = $rtoi($cos(3.14159265358979323846 * real'((2*i+1)*k) / 16.0) * 32768.0);
        check("R5 table K[0][1]", cq[0][1], 32138);
        check("R5 table K[1][3]", cq[1][3], -6392);

        // R1: reset state
        repeat (4) tick();
        @(negedge clk);
        check("R1 busy in reset", int'(busy), 0);
        check("R1 done in reset", int'(done), 0);
        @(posedge clk);
        #1;
        rst = 1'b0;
        tick();
        @(negedge clk);
        check("R1 busy after reset", int'(busy), 0);
        check("R1 done after reset", int'(done), 0);
        check("R1 coef after reset", int'(coef_out), 0);
        @(posedge clk);
        #1;

        // R3 then R2 wrap: 10 pushes, rejected start, 64 more pushes (74 total)
        for (int i = 0; i < 74; i++) src[i] = int'($urandom_range(255)) - 128;
        push_range(0, 10);
        try_ignored_start("R3 partial load");
        push_range(10, 74);
        expect_block("R2 wrapped load");
        run_xform("R2 wrap", 1'b0);
        drain(64);

        // Pattern tiles
        for (int p = 0; p < 7; p++) begin
            for (int i = 0; i < 64; i++) begin
                case (p)
                    0: src[i] = 100;
                    1: src[i] = -128;
                    2: src[i] = 127;
                    3: src[i] = (((i / 8) + (i % 8)) % 2 == 1) ? -128 : 127;
                    4: src[i] = (i == 0) ? 127 : 0;
                    default: src[i] = int'($urandom_range(255)) - 128;
                endcase
            end
            push_range(0, 64);
            expect_block("R6 pattern");
            run_xform("R5 pattern", (p == 0));
            if (p == 0) begin
                @(negedge clk);
                check("R6 DC of uniform 100", int'(coef_out), 12);
                @(posedge clk);
                #1;
                // R8: fresh load needed; done survives the rejected start
                try_ignored_start("R8 start after done");
                check("R4 done kept after rejected start", int'(done), 1);
            end
            drain(64);
            if (p == 0) begin
                // R7: readout wraps back to position 0
                expect_block("R7 wrapped readout");
                drain(64);
            end
        end

        tick();
        check("R7 scoreboard empty", exp_q.size(), 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule